// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master peripheral on a simple word-wide register bus. Software configures a serial clock divider, a clock polarity, a frame direction, watermark levels and chip-select behaviour through registers, then writes bytes into a transmit data register. Each queued byte is shifted out on MOSI as one 8-bit frame. The byte that arrives on MISO during that frame is stored in a receive queue, which software drains by reading the receive data register.

Each direction has its own byte queue with eight entries. Both queue data registers report full or empty in bit 31. Two pending flags compare the queue fill levels with programmable watermarks. These flags drive one level-sensitive interrupt through an enable mask. Configuration writes with out-of-range values leave the register unchanged, and no error is reported. The chip-select lines are active-low. The number of lines is a parameter.

Top module: `spim_top`

## Requirements
- R1: After reset the divider reads 3, the clock mode, select id, select mode, format, both watermarks and the enable mask read 0, the two delay words read 0x1001 and 0x1, the select-default word has one set bit per implemented line, both queues are empty, SCK is low, every select line is high and the interrupt is low.
- R2: A write to the transmit word queues its low byte. Each queued byte is sent as one frame, most significant bit first. MOSI changes only after falling SCK edges, and MISO is sampled on rising edges. SCK changes level every divider+1 clocks, so successive rising edges inside a frame are 2*(divider+1) clocks apart.
- R3: The transmit queue holds 8 bytes. A transmit write while the queue is full is discarded. Reading the transmit word returns 0x80000000 when the queue is full and 0 otherwise.
- R4: At the end of each frame the received byte is pushed into the receive queue. A read of the receive word returns 0x80000000 if the queue is empty. Otherwise it removes the oldest byte and returns it in bits 7:0.
- R5: While bit 3 of the format word is set, received bytes are discarded. A byte that arrives while the receive queue already holds 8 bytes is also discarded.
- R6: Pending bit 0 is 1 exactly while the transmit fill level is strictly below the transmit watermark. Pending bit 1 is 1 exactly while the receive fill level is strictly above the receive watermark. Both bits follow the fill levels in the same cycle.
- R7: The interrupt output is high exactly when some pending bit is set and the enable bit at the same position is also set.
- R8: A watermark write of 8 or more leaves that watermark unchanged.
- R9: A select-id write not below the line count, a select-mode write above 3, and a select-default write not below 2^(line count) are all discarded.
- R10: In select mode 0 or 1, the line chosen by the select id is low while a frame is in progress. In mode 2 that line is held low continuously. In mode 3 no line is driven active. Every line that is not active rests at its bit of the select-default word.
- R11: The read-only pending and receive words ignore writes. The flash control and flash format words (0x60, 0x64), every unassigned offset below 0x78, and every offset from 0x78 upward read 0 and ignore writes.
- R12: Byte offsets on the bus: transmit 0x48, receive 0x4C, transmit watermark 0x50, receive watermark 0x54, enable 0x70, pending 0x74, divider 0x00, clock mode 0x04 (bit 1 sets the idle level of SCK), select id 0x10, select default 0x14, select mode 0x18, delays 0x28 and 0x2C, format 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous release |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (pops the receive queue at the receive offset) |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of busRe |
| sckOut | output | 1 | Serial clock |
| mosiOut | output | 1 | Serial data out |
| misoIn | input | 1 | Serial data in |
| csOut | output | NCS | Active-low chip selects |
| irqOut | output | 1 | Level interrupt |

## Verification
A wrong fill count in either queue shows up in the same cycle on the pending bits and the interrupt. It also shows up at the next read of the data words, as a wrong bit 31, or as a byte that is lost or repeated in the receive order. A fault in the bit counter or the divider counter shows up within one frame as a wrong MOSI byte at the bench's serial model, or as a wrong gap between rising SCK edges. A select-line fault is visible while the first frame is still running. A fault in range rejection or address decode appears at the next read of the register concerned.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [3:0] {
    RD_ZERO, RD_DIV, RD_SCKMODE, RD_CSID, RD_CSDEF, RD_CSMODE, RD_DLY0,
    RD_DLY1, RD_FMT, RD_TX, RD_RX, RD_TXMARK, RD_RXMARK, RD_IE, RD_IP
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrDiv;
    logic wrSckMode;
    logic wrCsId;
    logic wrCsDef;
    logic wrCsMode;
    logic wrDly0;
    logic wrDly1;
    logic wrFmt;
    logic wrTxMark;
    logic wrRxMark;
    logic wrIe;
    logic txPush;
    logic rxPop;
    logic load;
    logic sckRise;
    logic sckFall;
    logic frameEnd;
    logic busy;
  } spimStrobe_t;

  localparam int FRAME_BITS = 8;
  localparam int DIR_BIT    = 3;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata  = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R3
  fifo_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              txEmpty,
  input  logic [DIV_W-1:0]  div,
  output spimStrobe_t       stb,
  output rdSel_e            rdSel
);

  localparam int REG_WORDS = 30;

  typedef enum logic {ST_IDLE, ST_SHIFT} engState_e;

  logic             inRange;
  logic [5:0]       idx;
  engState_e        state;
  logic [DIV_W-1:0] divCnt;
  logic [3:0]       halfCnt;
  logic             tick;

  assign inRange = (busAddr >> 2) < ADDR_W'(REG_WORDS);
  assign idx     = busAddr[7:2];

  always_comb begin
    rdSel = RD_ZERO;
    if (inRange) begin
      case (idx)
        6'h00:   rdSel = RD_DIV;
        6'h01:   rdSel = RD_SCKMODE;
        6'h04:   rdSel = RD_CSID;
        6'h05:   rdSel = RD_CSDEF;
        6'h06:   rdSel = RD_CSMODE;
        6'h0A:   rdSel = RD_DLY0;
        6'h0B:   rdSel = RD_DLY1;
        6'h10:   rdSel = RD_FMT;
        6'h12:   rdSel = RD_TX;
        6'h13:   rdSel = RD_RX;
        6'h14:   rdSel = RD_TXMARK;
        6'h15:   rdSel = RD_RXMARK;
        6'h1C:   rdSel = RD_IE;
        6'h1D:   rdSel = RD_IP;
        default: rdSel = RD_ZERO;
      endcase
    end
  end

  assign tick = (state == ST_SHIFT) && (divCnt == div);

  always_comb begin
    stb           = '0;
    stb.wrDiv     = busWe && rdSel == RD_DIV;
    stb.wrSckMode = busWe && rdSel == RD_SCKMODE;
    stb.wrCsId    = busWe && rdSel == RD_CSID;
    stb.wrCsDef   = busWe && rdSel == RD_CSDEF;
    stb.wrCsMode  = busWe && rdSel == RD_CSMODE;
    stb.wrDly0    = busWe && rdSel == RD_DLY0;
    stb.wrDly1    = busWe && rdSel == RD_DLY1;
    stb.wrFmt     = busWe && rdSel == RD_FMT;
    stb.wrTxMark  = busWe && rdSel == RD_TXMARK;
    stb.wrRxMark  = busWe && rdSel == RD_RXMARK;
    stb.wrIe      = busWe && rdSel == RD_IE;
    stb.txPush    = busWe && rdSel == RD_TX;
    stb.rxPop     = busRe && rdSel == RD_RX;
    stb.load      = (state == ST_IDLE) && !txEmpty;
    stb.sckRise   = tick && !halfCnt[0];
    stb.sckFall   = tick && halfCnt[0];
    stb.frameEnd  = tick && (halfCnt == 4'd15);
    stb.busy      = (state == ST_SHIFT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      halfCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          divCnt  <= '0;
          halfCnt <= '0;
          if (!txEmpty) state <= ST_SHIFT;
        end
        default: begin
          if (tick) begin
            divCnt  <= '0;
            halfCnt <= halfCnt + 1'b1;
            if (halfCnt == 4'd15) state <= ST_IDLE;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R2
  load_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> stb.busy);

  // R2
  end_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameEnd |=> !stb.busy);

endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
#(
  parameter int NCS   = 2,
  parameter int DIV_W = 12,
  parameter int DEPTH = 8,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int CSID_W = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  spimStrobe_t      stb,
  input  rdSel_e           rdSel,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  output logic             txEmpty,
  output logic [DIV_W-1:0] div,
  output logic             sckOut,
  output logic             mosiOut,
  input  logic             misoIn,
  output logic [NCS-1:0]   csOut,
  output logic             irqOut
);

  logic [DIV_W-1:0]  divReg;
  logic [1:0]        sckModeReg;
  logic [CSID_W-1:0] csIdReg;
  logic [NCS-1:0]    csDefReg;
  logic [1:0]        csModeReg;
  logic [31:0]       dly0Reg, dly1Reg;
  logic [7:0]        fmtReg;
  logic [CW-1:0]     txMark, rxMark;
  logic [1:0]        ieReg;
  logic [7:0]        txSh, rxSh;
  logic              sckReg;

  logic [7:0]    txRdata, rxRdata;
  logic          txFull, rxFull, rxEmpty, rxPushReq;
  logic [CW-1:0] txCount, rxCount;
  logic          pendTx, pendRx;

  assign rxPushReq = stb.frameEnd && !fmtReg[DIR_BIT];

  spim_fifo #(.DEPTH(DEPTH), .W(8)) txFifo_i (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pop(stb.load),
    .wdata(busWdata[7:0]), .rdata(txRdata), .full(txFull),
    .empty(txEmpty), .count(txCount));

  spim_fifo #(.DEPTH(DEPTH), .W(8)) rxFifo_i (
    .clk(clk), .rstN(rstN), .push(rxPushReq), .pop(stb.rxPop),
    .wdata(rxSh), .rdata(rxRdata), .full(rxFull),
    .empty(rxEmpty), .count(rxCount));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg     <= DIV_W'(3);
      sckModeReg <= '0;
      csIdReg    <= '0;
      csDefReg   <= '1;
      csModeReg  <= '0;
      dly0Reg    <= 32'h0000_1001;
      dly1Reg    <= 32'h0000_0001;
      fmtReg     <= '0;
      txMark     <= '0;
      rxMark     <= '0;
      ieReg      <= '0;
    end else begin
      if (stb.wrDiv)     divReg     <= busWdata[DIV_W-1:0];
      if (stb.wrSckMode) sckModeReg <= busWdata[1:0];
      if (stb.wrCsId && busWdata < 32'(NCS))      csIdReg   <= busWdata[CSID_W-1:0];
      if (stb.wrCsDef && (busWdata >> NCS) == '0) csDefReg  <= busWdata[NCS-1:0];
      if (stb.wrCsMode && busWdata <= 32'd3)      csModeReg <= busWdata[1:0];
      if (stb.wrDly0)    dly0Reg    <= busWdata;
      if (stb.wrDly1)    dly1Reg    <= busWdata;
      if (stb.wrFmt)     fmtReg     <= busWdata[7:0];
      if (stb.wrTxMark && busWdata < 32'(DEPTH)) txMark <= busWdata[CW-1:0];
      if (stb.wrRxMark && busWdata < 32'(DEPTH)) rxMark <= busWdata[CW-1:0];
      if (stb.wrIe)      ieReg      <= busWdata[1:0];
    end
  end

  // serial shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '0;
      rxSh   <= '0;
      sckReg <= 1'b0;
    end else begin
      if (stb.load)                          txSh <= txRdata;
      else if (stb.sckFall && !stb.frameEnd) txSh <= {txSh[6:0], 1'b0};
      if (stb.sckRise) rxSh <= {rxSh[6:0], misoIn};
      if (stb.sckRise)      sckReg <= 1'b1;
      else if (stb.sckFall) sckReg <= 1'b0;
    end
  end

  assign div     = divReg;
  assign sckOut  = sckReg ^ sckModeReg[1];
  assign mosiOut = txSh[7];

  assign pendTx = txCount < txMark;
  assign pendRx = rxCount > rxMark;
  assign irqOut = |({pendRx, pendTx} & ieReg);

  for (genvar i = 0; i < NCS; i++) begin : gCs
    logic active;
    assign active = (csIdReg == CSID_W'(i)) &&
                    ((csModeReg == 2'd2) || (csModeReg != 2'd3 && stb.busy));
    assign csOut[i] = active ? 1'b0 : csDefReg[i];
  end

  always_comb begin
    case (rdSel)
      RD_DIV:     busRdata = 32'(divReg);
      RD_SCKMODE: busRdata = 32'(sckModeReg);
      RD_CSID:    busRdata = 32'(csIdReg);
      RD_CSDEF:   busRdata = 32'(csDefReg);
      RD_CSMODE:  busRdata = 32'(csModeReg);
      RD_DLY0:    busRdata = dly0Reg;
      RD_DLY1:    busRdata = dly1Reg;
      RD_FMT:     busRdata = 32'(fmtReg);
      RD_TX:      busRdata = {txFull, 31'b0};
      RD_RX:      busRdata = rxEmpty ? 32'h8000_0000 : {24'b0, rxRdata};
      RD_TXMARK:  busRdata = 32'(txMark);
      RD_RXMARK:  busRdata = 32'(rxMark);
      RD_IE:      busRdata = 32'(ieReg);
      RD_IP:      busRdata = {30'b0, pendRx, pendTx};
      default:    busRdata = '0;
    endcase
  end

  // R8
  mark_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txMark < CW'(DEPTH)) && (rxMark < CW'(DEPTH)));

  // R10
  cs_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csModeReg == 2'd3) |-> (csOut == csDefReg));

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busy && sckReg) |-> $stable(mosiOut));

  // R4
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rxPop && !rxEmpty && !rxPushReq) |=> (rxCount == $past(rxCount) - 1'b1));

endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int NCS        = 2,
  parameter int ADDR_W     = 12,
  parameter int DIV_W      = 12,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  output logic [NCS-1:0]    csOut,
  output logic              irqOut
);

  spimStrobe_t      stb;
  rdSel_e           rdSel;
  logic             txEmpty;
  logic [DIV_W-1:0] div;

  spim_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .txEmpty(txEmpty), .div(div), .stb(stb), .rdSel(rdSel));

  spim_dp #(.NCS(NCS), .DIV_W(DIV_W), .DEPTH(FIFO_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .busWdata(busWdata),
    .busRdata(busRdata), .txEmpty(txEmpty), .div(div), .sckOut(sckOut),
    .mosiOut(mosiOut), .misoIn(misoIn), .csOut(csOut), .irqOut(irqOut));

endmodule

// File: tb/spim_top_tb_top.sv
module spim_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCS = 2;

  localparam logic [11:0] A_DIV = 12'h000, A_SCKM = 12'h004, A_CSID = 12'h010,
    A_CSDEF = 12'h014, A_CSMODE = 12'h018, A_DLY0 = 12'h028, A_DLY1 = 12'h02C,
    A_FMT = 12'h040, A_TX = 12'h048, A_RX = 12'h04C, A_TXM = 12'h050,
    A_RXM = 12'h054, A_FCTL = 12'h060, A_IE = 12'h070, A_IP = 12'h074;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic sckOut, mosiOut, misoIn, irqOut;
  logic [NCS-1:0] csOut;

  int nChk = 0, nBad = 0;
  bit finished = 0;
  bit monEn = 1;
  int cyc = 0;
  int riseCnt = 0;
  int bitIdx = 0;
  int lastRise = 0;
  int divModel = 3;
  logic [7:0] shByte = '0;
  logic [7:0] txExp[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spim_top #(.NCS(NCS)) dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sckOut(sckOut),
    .mosiOut(mosiOut), .misoIn(misoIn), .csOut(csOut), .irqOut(irqOut));

  function automatic logic [7:0] respOf(input int f);
    return 8'h3C + 8'(f) * 8'h1D;
  endfunction

  function automatic logic misoBit(input int r);
    logic [7:0] b;
    b = respOf(r >> 3);
    return b[7 - (r & 7)];
  endfunction

  assign misoIn = misoBit(riseCnt);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // serial monitor: compares sent bytes with the scoreboard queue
  always @(posedge sckOut) begin
    if (monEn && rstN) begin
      if (bitIdx != 0)
        chk((cyc - lastRise) == 2 * (divModel + 1), "R2 sck period",
            32'(cyc - lastRise), 32'(2 * (divModel + 1)));
      lastRise = cyc;
      shByte = {shByte[6:0], mosiOut};
      bitIdx++;
      riseCnt++;
      if (bitIdx == 8) begin
        bitIdx = 0;
        if (txExp.size() == 0) chk(0, "R2 unexpected frame", 32'(shByte), 0);
        else begin
          logic [7:0] e;
          e = txExp.pop_front();
          chk(shByte == e, "R2 mosi byte", 32'(shByte), 32'(e));
        end
      end
    end
  end

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic rdChk(input logic [11:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    busRead(a, d);
    chk(d == e, tag, d, e);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit sent);
    busWrite(A_TX, {24'hABCDEF, b});
    if (sent) txExp.push_back(b);
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 0);
    summary();
  end

  initial begin
    int base;
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);

    // R1 reset state
    rdChk(A_DIV, 3, "R1 divider");
    rdChk(A_SCKM, 0, "R1 clock mode");
    rdChk(A_DLY0, 32'h1001, "R1 delay0");
    rdChk(A_DLY1, 1, "R1 delay1");
    rdChk(A_CSDEF, 3, "R1 select default");
    rdChk(A_CSMODE, 0, "R1 select mode");
    rdChk(A_TXM, 0, "R1 tx watermark");
    rdChk(A_RX, 32'h8000_0000, "R1 rx empty");
    rdChk(A_TX, 0, "R3 tx not full");
    rdChk(A_IP, 0, "R1 pending");
    chk(csOut == 2'b11, "R1 select lines", 32'(csOut), 3);
    chk(sckOut == 1'b0 && irqOut == 1'b0, "R1 sck/irq", {sckOut, irqOut}, 0);

    // R11 reserved, flash, read-only, out of range
    busWrite(12'h008, 32'hFFFF_FFFF);
    rdChk(12'h008, 0, "R11 reserved");
    busWrite(A_FCTL, 32'h1);
    rdChk(A_FCTL, 0, "R11 flash ctl");
    busWrite(A_IP, 32'h3);
    rdChk(A_IP, 0, "R11 pending ro");
    busWrite(A_RX, 32'h55);
    rdChk(A_RX, 32'h8000_0000, "R11 rx ro");
    busWrite(12'h080, 32'h77);
    rdChk(12'h080, 0, "R11 out of range");
    busWrite(12'h078, 32'h77);
    rdChk(A_DIV, 3, "R11 divider untouched");

    // R8 watermark limits
    busWrite(A_TXM, 8);
    rdChk(A_TXM, 0, "R8 tx mark 8");
    busWrite(A_TXM, 7);
    rdChk(A_TXM, 7, "R8 tx mark 7");
    busWrite(A_RXM, 9);
    rdChk(A_RXM, 0, "R8 rx mark 9");
    busWrite(A_RXM, 5);
    rdChk(A_RXM, 5, "R8 rx mark 5");

    // R9 select register limits
    busWrite(A_CSID, 2);
    rdChk(A_CSID, 0, "R9 select id 2");
    busWrite(A_CSID, 1);
    rdChk(A_CSID, 1, "R9 select id 1");
    busWrite(A_CSMODE, 4);
    rdChk(A_CSMODE, 0, "R9 select mode 4");
    busWrite(A_CSDEF, 4);
    rdChk(A_CSDEF, 3, "R9 select default 4");
    busWrite(A_CSDEF, 1);
    rdChk(A_CSDEF, 1, "R9 select default 1");
    chk(csOut == 2'b01, "R10 idle default", 32'(csOut), 1);
    busWrite(A_CSDEF, 3);
    busWrite(A_CSID, 0);

    // R6/R7 tx watermark
    busWrite(A_TXM, 2);
    rdChk(A_IP, 1, "R6 tx pending");
    chk(irqOut == 1'b0, "R7 masked", 32'(irqOut), 0);
    busWrite(A_IE, 1);
    chk(irqOut == 1'b1, "R7 enabled", 32'(irqOut), 1);
    busWrite(A_IE, 0);
    busWrite(A_TXM, 0);
    busWrite(A_RXM, 0);

    // R2/R4/R10 two frames, divider 1
    busWrite(A_DIV, 1);
    divModel = 1;
    base = riseCnt >> 3;
    sendByte(8'hA5, 1);
    sendByte(8'h3C, 1);
    waitClk(4);
    chk(csOut == 2'b10, "R10 auto select active", 32'(csOut), 2);
    waitClk(80);
    chk(csOut == 2'b11, "R10 auto select released", 32'(csOut), 3);
    rdChk(A_IP, 2, "R6 rx pending");
    busWrite(A_IE, 2);
    chk(irqOut == 1'b1, "R7 rx irq", 32'(irqOut), 1);
    rdChk(A_RX, 32'(respOf(base)), "R4 rx byte 0");
    rdChk(A_IP, 2, "R6 rx pending one left");
    rdChk(A_RX, 32'(respOf(base + 1)), "R4 rx byte 1");
    rdChk(A_IP, 0, "R6 rx drained");
    chk(irqOut == 1'b0, "R7 irq low", 32'(irqOut), 0);
    rdChk(A_RX, 32'h8000_0000, "R4 rx empty");
    busWrite(A_IE, 0);

    // R2 period at divider 2
    busWrite(A_DIV, 2);
    divModel = 2;
    base = riseCnt >> 3;
    sendByte(8'h81, 1);
    waitClk(60);
    rdChk(A_RX, 32'(respOf(base)), "R4 rx byte at div 2");

    // R3/R5 both queues full
    busWrite(A_DIV, 20);
    divModel = 20;
    base = riseCnt >> 3;
    for (int k = 0; k < 9; k++) sendByte(8'(8'h10 + k * 7), 1);
    sendByte(8'hEE, 0);
    rdChk(A_TX, 32'h8000_0000, "R3 tx full");
    waitClk(3150);
    rdChk(A_TX, 0, "R3 tx drained");
    chk(txExp.size() == 0, "R3 all queued bytes sent", 32'(txExp.size()), 0);
    for (int k = 0; k < 8; k++)
      rdChk(A_RX, 32'(respOf(base + k)), "R5 rx order when full");
    rdChk(A_RX, 32'h8000_0000, "R5 ninth byte dropped");

    // R5 transmit-only direction
    busWrite(A_DIV, 0);
    divModel = 0;
    busWrite(A_FMT, 8);
    sendByte(8'h5A, 1);
    sendByte(8'hC3, 1);
    waitClk(50);
    rdChk(A_RX, 32'h8000_0000, "R5 direction discards");
    rdChk(A_FMT, 8, "R12 format readback");
    busWrite(A_FMT, 0);

    // R10 hold and off modes
    busWrite(A_CSMODE, 2);
    chk(csOut == 2'b10, "R10 hold id0", 32'(csOut), 2);
    busWrite(A_CSID, 1);
    chk(csOut == 2'b01, "R10 hold id1", 32'(csOut), 1);
    busWrite(A_CSMODE, 3);
    chk(csOut == 2'b11, "R10 off mode", 32'(csOut), 3);
    busWrite(A_CSMODE, 0);

    // R12 clock polarity bit
    monEn = 0;
    busWrite(A_SCKM, 2);
    waitClk(1);
    chk(sckOut == 1'b1, "R12 sck idle high", 32'(sckOut), 1);
    rdChk(A_SCKM, 2, "R12 clock mode readback");

    waitClk(5);
    summary();
  end

endmodule